// File: doc/BRIEF.md
# Two-Dimensional DMA Address Sequencer

This block produces the word address stream for one channel of a strided two-dimensional DMA engine. A start strobe captures a word start address (byte address divided by four), a line length, a line pitch and a line count. In the normal mode the sequencer emits the words of one line at consecutive addresses. It then jumps to the start of the next line, one pitch further on, and repeats until the last line is done. It then pulses an end-of-transfer output and goes idle.

A line length of zero selects a circular mode for ping-pong buffering. The sequencer sweeps a region of pitch × (count + 1) words, returns to the region start and continues without end. It pulses a half-buffer output each time the first half and then the second half of the region has been consumed. A stop input ends either mode at once.

The data mover takes one word per cycle in which its advance signal is high. The address is held while advance is low. A configuration that cannot work is refused with a one-cycle error pulse, and the block stays idle.

Top module: `addr2d_seq`

## Requirements
- R1: After reset, busy, done_pulse, half_pulse and cfg_err are all 0.
- R2: An accepted start with a non-zero line length sets busy and presents cfg_base as the word address on the next cycle.
- R3: While busy, the address increases by exactly one after each cycle with adv high inside a line, and holds its value in every cycle with adv low.
- R4: Once the last word of a line has been advanced, the address becomes that line's start address plus cfg_pitch.
- R5: cfg_lines holds the line count minus one. After cfg_len × (cfg_lines + 1) advances, done_pulse is high for exactly one cycle and busy falls in that same cycle.
- R6: With cfg_len = 0 the address runs from cfg_base through cfg_base + R − 1, where R = cfg_pitch × (cfg_lines + 1). It then returns to cfg_base and keeps running; done_pulse is never raised.
- R7: In loop mode, half_pulse is high for one cycle after the advance of region offset floor(R/2) − 1 and after the advance of offset R − 1, giving two pulses per lap.
- R8: stop clears busy on the next cycle in either mode. It takes precedence over adv and start, and no done_pulse or half_pulse follows it.
- R9: A start with cfg_len ≠ 0 and cfg_pitch < cfg_len, or with cfg_len = 0 and R < 2, yields cfg_err high for one cycle, and busy stays 0.
- R10: A start that arrives while busy is ignored: the address sequence and the mode are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Capture configuration and begin (when idle) |
| stop | input | 1 | Abort the current sequence |
| cfg_base | input | AW | Start word address |
| cfg_len | input | LW | Words per line; 0 selects loop mode |
| cfg_pitch | input | LW | Words from one line start to the next |
| cfg_lines | input | CW | Number of lines minus one |
| adv | input | 1 | Data mover consumed the current address |
| addr | output | AW | Current word address |
| busy | output | 1 | A sequence is running |
| done_pulse | output | 1 | Normal-mode transfer complete |
| half_pulse | output | 1 | Loop-mode half region consumed |
| cfg_err | output | 1 | Start refused for bad configuration |

## Verification
A wrong word or line counter shows up as an address off the arithmetic sequence base + line·pitch + word. This is visible in the first cycle after the faulty advance, because every advance is compared. A wrong completion count shows up as a done_pulse or busy fall one or more advances early or late, at the end of each run of the sweep. In loop mode, a wrong region or half boundary moves the wrap address or a half_pulse by at least one advance within the first lap. A stop that is not honoured leaves busy high or lets a pulse appear in the cycle right after stop.

// File: rtl/addr2d_pkg.sv
package addr2d_pkg;
  typedef enum logic {
    MODE_LINE = 1'b0,
    MODE_LOOP = 1'b1
  } walk_mode_e;
endpackage

// File: rtl/addr2d_cfg_check.sv
module addr2d_cfg_check #(
  parameter int LW = 6,
  parameter int CW = 6,
  parameter int RW = LW + CW + 1
) (
  input  logic [LW-1:0] len,
  input  logic [LW-1:0] pitch,
  input  logic [CW-1:0] lines,
  output logic          loop_mode,
  output logic          bad,
  output logic [RW-1:0] region_last,
  output logic [RW-1:0] half_last
);
  logic [RW-1:0] region;

  always_comb begin
    region      = RW'(pitch) * (RW'(lines) + RW'(1));
    loop_mode   = (len == '0);
    bad         = loop_mode ? (region < RW'(2)) : (pitch < len);
    region_last = region - RW'(1);
    half_last   = (region >> 1) - RW'(1);
  end
endmodule

// File: rtl/addr2d_line_walker.sv
module addr2d_line_walker #(
  parameter int AW = 16,
  parameter int LW = 6,
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          launch,
  input  logic          stop,
  input  logic          adv,
  input  logic [AW-1:0] base,
  input  logic [LW-1:0] len,
  input  logic [LW-1:0] pitch,
  input  logic [CW-1:0] lines,
  output logic [AW-1:0] addr_q,
  output logic          busy_q,
  output logic          done_q
);
  logic [AW-1:0] lbase_q;
  logic [LW-1:0] len_q, pitch_q, word_q;
  logic [CW-1:0] lines_q, line_q;
  logic          last_word, last_line;

  assign last_word = (word_q == len_q - LW'(1));
  assign last_line = (line_q == lines_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      addr_q  <= '0;
      lbase_q <= '0;
      len_q   <= '0;
      pitch_q <= '0;
      lines_q <= '0;
      word_q  <= '0;
      line_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (stop) begin
        busy_q <= 1'b0;
      end else if (launch) begin
        busy_q  <= 1'b1;
        addr_q  <= base;
        lbase_q <= base;
        len_q   <= len;
        pitch_q <= pitch;
        lines_q <= lines;
        word_q  <= '0;
        line_q  <= '0;
      end else if (busy_q && adv) begin
        if (last_word) begin
          if (last_line) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end else begin
            lbase_q <= lbase_q + AW'(pitch_q);
            addr_q  <= lbase_q + AW'(pitch_q);
            word_q  <= '0;
            line_q  <= line_q + CW'(1);
          end
        end else begin
          addr_q <= addr_q + AW'(1);
          word_q <= word_q + LW'(1);
        end
      end
    end
  end

  assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (busy_q && !adv && !stop && !launch) |=> $stable(addr_q));

  assert_step_R3: assert property (@(posedge clk) disable iff (rst)
    (busy_q && adv && !stop && !launch && !last_word) |=> (addr_q == $past(addr_q) + AW'(1)));

  assert_done_single_R5: assert property (@(posedge clk) disable iff (rst)
    done_q |-> (!busy_q && !$past(done_q)));

  assert_stop_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    stop |=> (!busy_q && !done_q));
endmodule

// File: rtl/addr2d_loop_walker.sv
module addr2d_loop_walker #(
  parameter int AW = 16,
  parameter int RW = 13
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          launch,
  input  logic          stop,
  input  logic          adv,
  input  logic [AW-1:0] base,
  input  logic [RW-1:0] region_last,
  input  logic [RW-1:0] half_last,
  output logic [AW-1:0] addr_q,
  output logic          busy_q,
  output logic          half_q
);
  logic [AW-1:0] base_q;
  logic [RW-1:0] pos_q, rlast_q, hlast_q;
  logic          at_end;

  assign at_end = (pos_q == rlast_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      half_q  <= 1'b0;
      addr_q  <= '0;
      base_q  <= '0;
      pos_q   <= '0;
      rlast_q <= '0;
      hlast_q <= '0;
    end else begin
      half_q <= 1'b0;
      if (stop) begin
        busy_q <= 1'b0;
      end else if (launch) begin
        busy_q  <= 1'b1;
        addr_q  <= base;
        base_q  <= base;
        pos_q   <= '0;
        rlast_q <= region_last;
        hlast_q <= half_last;
      end else if (busy_q && adv) begin
        half_q <= at_end || (pos_q == hlast_q);
        if (at_end) begin
          pos_q  <= '0;
          addr_q <= base_q;
        end else begin
          pos_q  <= pos_q + RW'(1);
          addr_q <= addr_q + AW'(1);
        end
      end
    end
  end

  assert_wrap_R6: assert property (@(posedge clk) disable iff (rst)
    (busy_q && adv && !stop && !launch && at_end) |=> (addr_q == base_q));

  assert_half_cause_R7: assert property (@(posedge clk) disable iff (rst)
    half_q |-> $past(busy_q && adv));

  assert_stop_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    stop |=> (!busy_q && !half_q));
endmodule

// File: rtl/addr2d_seq.sv
module addr2d_seq
  import addr2d_pkg::*;
#(
  parameter int AW = 16,
  parameter int LW = 6,
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          stop,
  input  logic [AW-1:0] cfg_base,
  input  logic [LW-1:0] cfg_len,
  input  logic [LW-1:0] cfg_pitch,
  input  logic [CW-1:0] cfg_lines,
  input  logic          adv,
  output logic [AW-1:0] addr,
  output logic          busy,
  output logic          done_pulse,
  output logic          half_pulse,
  output logic          cfg_err
);
  localparam int RW = LW + CW + 1;

  logic          loop_sel, cfg_bad, accept, go_line, go_loop;
  logic [RW-1:0] region_last, half_last;
  logic [AW-1:0] line_addr, loop_addr;
  logic          line_busy, loop_busy;
  walk_mode_e    mode_q;

  addr2d_cfg_check #(.LW(LW), .CW(CW), .RW(RW)) u_check (
    .len(cfg_len), .pitch(cfg_pitch), .lines(cfg_lines),
    .loop_mode(loop_sel), .bad(cfg_bad),
    .region_last(region_last), .half_last(half_last)
  );

  assign busy    = line_busy || loop_busy;
  assign accept  = start && !stop && !busy;
  assign go_line = accept && !cfg_bad && !loop_sel;
  assign go_loop = accept && !cfg_bad && loop_sel;

  addr2d_line_walker #(.AW(AW), .LW(LW), .CW(CW)) u_line (
    .clk(clk), .rst(rst), .launch(go_line), .stop(stop), .adv(adv),
    .base(cfg_base), .len(cfg_len), .pitch(cfg_pitch), .lines(cfg_lines),
    .addr_q(line_addr), .busy_q(line_busy), .done_q(done_pulse)
  );

  addr2d_loop_walker #(.AW(AW), .RW(RW)) u_loop (
    .clk(clk), .rst(rst), .launch(go_loop), .stop(stop), .adv(adv),
    .base(cfg_base), .region_last(region_last), .half_last(half_last),
    .addr_q(loop_addr), .busy_q(loop_busy), .half_q(half_pulse)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= MODE_LINE;
      cfg_err <= 1'b0;
    end else begin
      cfg_err <= accept && cfg_bad;
      if (go_line) mode_q <= MODE_LINE;
      else if (go_loop) mode_q <= MODE_LOOP;
    end
  end

  assign addr = (mode_q == MODE_LOOP) ? loop_addr : line_addr;

  assert_one_walker_R10: assert property (@(posedge clk) disable iff (rst)
    !(line_busy && loop_busy));

  assert_mode_kept_R10: assert property (@(posedge clk) disable iff (rst)
    (busy && start && !stop) |=> (mode_q == $past(mode_q)));

  assert_err_idle_R9: assert property (@(posedge clk) disable iff (rst)
    cfg_err |-> !busy);

  assert_loop_no_done_R6: assert property (@(posedge clk) disable iff (rst)
    loop_busy |-> !done_pulse);
endmodule

// File: tb/tb_addr2d_seq.sv
`timescale 1ns/1ps
module tb_addr2d_seq;
  localparam int AW = 16;
  localparam int LW = 6;
  localparam int CW = 6;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0, stop = 1'b0, adv = 1'b0;
  logic [AW-1:0] cfg_base = '0;
  logic [LW-1:0] cfg_len = '0, cfg_pitch = '0;
  logic [CW-1:0] cfg_lines = '0;
  logic [AW-1:0] addr;
  logic          busy, done_pulse, half_pulse, cfg_err;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  addr2d_seq #(.AW(AW), .LW(LW), .CW(CW)) dut (
    .clk(clk), .rst(rst), .start(start), .stop(stop),
    .cfg_base(cfg_base), .cfg_len(cfg_len), .cfg_pitch(cfg_pitch),
    .cfg_lines(cfg_lines), .adv(adv), .addr(addr), .busy(busy),
    .done_pulse(done_pulse), .half_pulse(half_pulse), .cfg_err(cfg_err)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_start(input int b, input int len, input int pit, input int nl);
    @(negedge clk);
    cfg_base = AW'(b); cfg_len = LW'(len); cfg_pitch = LW'(pit); cfg_lines = CW'(nl);
    start = 1'b1; adv = 1'b0;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic run_line(input int b, input int len, input int pit, input int nl, input int pat);
    int total;
    int k;
    int cyc;
    total = len * (nl + 1);
    k = 0;
    cyc = 0;
    do_start(b, len, pit, nl);
    chk(busy == 1'b1, "R2", busy, 1);
    chk(addr == AW'(b), "R2", addr, b);
    while (k < total) begin
      int exp;
      bit a;
      exp = b + (k / len) * pit + (k % len);
      if (k > 0 && (k % len) == 0) chk(addr == AW'(exp), "R4", addr, exp);
      else chk(addr == AW'(exp), "R3", addr, exp);
      chk(busy == 1'b1 && done_pulse == 1'b0, "R5", {busy, done_pulse}, 2);
      a = ((cyc + pat) % 3) != 2;
      adv = a;
      @(negedge clk);
      if (a) k++;
      cyc++;
    end
    adv = 1'b0;
    chk(done_pulse == 1'b1, "R5", done_pulse, 1);
    chk(busy == 1'b0, "R5", busy, 0);
    @(negedge clk);
    chk(done_pulse == 1'b0, "R5", done_pulse, 0);
  endtask

  task automatic run_loop(input int b, input int pit, input int nl, input int pat);
    int rsz;
    int h;
    int k;
    int cyc;
    bit exp_half;
    rsz = pit * (nl + 1);
    h = rsz / 2;
    k = 0;
    cyc = 0;
    exp_half = 1'b0;
    do_start(b, 0, pit, nl);
    chk(busy == 1'b1 && addr == AW'(b), "R6", addr, b);
    while (k < 2 * rsz + h) begin
      int exp;
      bit a;
      exp = b + (k % rsz);
      chk(addr == AW'(exp), "R6", addr, exp);
      chk(busy == 1'b1 && done_pulse == 1'b0, "R6", {busy, done_pulse}, 2);
      chk(half_pulse == exp_half, "R7", half_pulse, exp_half);
      a = ((cyc + pat) % 4) != 3;
      adv = a;
      @(negedge clk);
      exp_half = a && (((k % rsz) == h - 1) || ((k % rsz) == rsz - 1));
      if (a) k++;
      cyc++;
    end
    chk(half_pulse == exp_half, "R7", half_pulse, exp_half);
    stop = 1'b1; adv = 1'b1;
    @(negedge clk);
    stop = 1'b0;
    for (int i = 0; i < 3; i++) begin
      chk(busy == 1'b0 && half_pulse == 1'b0, "R8", {busy, half_pulse}, 0);
      @(negedge clk);
    end
    adv = 1'b0;
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog actual %0d expected %0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(busy == 0 && done_pulse == 0 && half_pulse == 0 && cfg_err == 0, "R1",
        {busy, done_pulse, half_pulse, cfg_err}, 0);

    // R2 R3 R4 R5: normal mode sweep over length, pitch, line count
    for (int len = 1; len <= 3; len++)
      for (int pit = len; pit <= len + 2; pit++)
        for (int nl = 0; nl <= 2; nl++)
          run_line(40 + len * 7 + nl, len, pit, nl, len + nl);

    // R6 R7 R8: loop mode sweep, stopped after two and a half laps
    for (int pit = 1; pit <= 3; pit++)
      for (int nl = 0; nl <= 3; nl++)
        if (pit * (nl + 1) >= 2) run_loop(300 + pit * 16 + nl, pit, nl, pit + nl);

    // R8: stop on the final advance suppresses done_pulse
    do_start(900, 2, 2, 0);
    adv = 1'b1;
    @(negedge clk);
    chk(addr == AW'(901), "R3", addr, 901);
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0; adv = 1'b0;
    chk(busy == 1'b0 && done_pulse == 1'b0, "R8", {busy, done_pulse}, 0);
    @(negedge clk);
    chk(done_pulse == 1'b0, "R8", done_pulse, 0);

    // R10: starts while busy are ignored
    do_start(100, 2, 3, 1);
    adv = 1'b1;
    @(negedge clk);
    adv = 1'b0;
    cfg_base = AW'(500); cfg_len = '0; start = 1'b1;
    @(negedge clk);
    chk(addr == AW'(101) && busy == 1'b1, "R10", addr, 101);
    cfg_len = LW'(1);
    @(negedge clk);
    start = 1'b0;
    chk(addr == AW'(101), "R10", addr, 101);
    adv = 1'b1;
    @(negedge clk);
    chk(addr == AW'(103), "R10", addr, 103);
    adv = 1'b0; stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
    chk(busy == 1'b0, "R8", busy, 0);

    // R9: configuration errors
    do_start(10, 3, 2, 0);
    chk(cfg_err == 1'b1 && busy == 1'b0, "R9", {cfg_err, busy}, 2);
    @(negedge clk);
    chk(cfg_err == 1'b0 && busy == 1'b0, "R9", {cfg_err, busy}, 0);
    do_start(10, 0, 1, 0);
    chk(cfg_err == 1'b1 && busy == 1'b0, "R9", {cfg_err, busy}, 2);
    do_start(10, 0, 0, 5);
    chk(cfg_err == 1'b1 && busy == 1'b0, "R9", {cfg_err, busy}, 2);
    @(negedge clk);
    chk(cfg_err == 1'b0, "R9", cfg_err, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule